// File: doc/BRIEF.md
# Dual-Side Parallel Port with Edge Interrupts

This block is a bus-attached peripheral port with two identical sides, A and B. A side has a byte of port pins, a data latch and a direction register that share one bus offset, and a control register. The host reaches the four registers through a 2-bit offset, a chip select, read and write strobes and byte-wide data. The read path is combinational. Writes take effect on the clock edge.

Each side also has two control lines. The input line passes through a synchronizer and an edge detector. An edge of the programmed polarity latches a status flag, and that flag can drive the side's interrupt output. The second line can be programmed to a fixed output level, and otherwise it is released as an input. A driver uses the port by first writing directions with the select bit clear, then setting the select bit, and from then on moving data through the same offset.

Top module: `edge_irq_port`

## Requirements
- R1: Offsets are decoded as 0 = side A data/direction, 1 = side A control, 2 = side B data/direction, 3 = side B control. The read bus is all zeros whenever chip select and read are not both high.
- R2: Control bit 2 steers the data offset. When it is 0, reads and writes go to the direction register. When it is 1, they go to the data latch.
- R3: A pin whose direction bit is 1 is enabled as an output and drives its data-latch bit. A data read returns the latch bit for output pins and the pin level for input pins.
- R4: Control bit 1 sets the edge polarity of control line 1: 0 selects falling edges and 1 selects rising edges. An edge of the other polarity leaves the flag unchanged. After a synchronized edge, the flag (control bit 7) is set on the third rising clock edge after the line changes.
- R5: The flag is set by an active edge whether or not interrupts are enabled. The side's interrupt output is high only while both the flag and control bit 0 are 1.
- R6: A read of the data offset while control bit 2 is 1 clears that side's flag. A read of the direction register does not clear it. If an active edge arrives in the same cycle as the clearing read, the edge wins.
- R7: A control write changes bits 5..0 only. Bit 7 reads back as the flag and is not affected by writes. Bit 6 always reads 0.
- R8: When control bits 5 and 4 are both 1, line 2 is output-enabled and its level equals control bit 3. In every other setting its output enable is 0.
- R9: Reset clears every register. After reset all pins and both line-2 signals are inputs, and both interrupt outputs are low.
- R10: The two sides are independent. An edge, a flag or a register write on one side has no effect on the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data (combinational) |
| a_pin_in | input | DATA_W | Side A pin levels |
| a_pin_out | output | DATA_W | Side A output values |
| a_pin_oe | output | DATA_W | Side A per-pin output enable |
| a_line1 | input | 1 | Side A edge-interrupt input line |
| a_line2_out | output | 1 | Side A line-2 level |
| a_line2_oe | output | 1 | Side A line-2 output enable |
| a_irq | output | 1 | Side A interrupt |
| b_pin_in | input | DATA_W | Side B pin levels |
| b_pin_out | output | DATA_W | Side B output values |
| b_pin_oe | output | DATA_W | Side B per-pin output enable |
| b_line1 | input | 1 | Side B edge-interrupt input line |
| b_line2_out | output | 1 | Side B line-2 level |
| b_line2_oe | output | 1 | Side B line-2 output enable |
| b_irq | output | 1 | Side B interrupt |

## Verification
The port data path is tested with mixed direction masks over pin levels that differ from the latch contents. Because of this, a read that mixes latch and pin bits in the wrong way gives a value that differs from the expected one. Edges are applied in both directions under each polarity setting, so a detector that ignores polarity sets the flag on the wrong edge. The flag is then cleared once through a direction read, which must leave it set, and once through a data read, which must clear it. Changing the enable bit while a flag is pending shows that the flag and the interrupt output are held separately. A stimulus applied to side B alone shows whether state leaks from one side to the other.

// File: rtl/edge_irq_port_pkg.sv
package edge_irq_port_pkg;
   // control register bit positions (software depends on these)
   localparam int CB_FLAG  = 7;
   localparam int CB_RSV   = 6;
   localparam int CB_L2EN  = 5;
   localparam int CB_L2FIX = 4;
   localparam int CB_L2LVL = 3;
   localparam int CB_SEL   = 2;
   localparam int CB_POL   = 1;
   localparam int CB_IEN   = 0;
   localparam int CTL_W    = 6;   // writable bits 5..0

   typedef enum logic [1:0] {
      OFF_A_DATA = 2'd0,
      OFF_A_CTL  = 2'd1,
      OFF_B_DATA = 2'd2,
      OFF_B_CTL  = 2'd3
   } port_off_e;
endpackage

// File: rtl/eip_edge_sync.sv
module eip_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   input  logic rise_sel,
   output logic hit
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   if (STAGES < 2) begin : g_bad
      $error("eip_edge_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], line_in};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   logic cur;
   assign cur = chain_q[STAGES-1];
   assign hit = rise_sel ? (cur & ~prev_q) : (~cur & prev_q);
endmodule

// File: rtl/eip_side.sv
module eip_side
   import edge_irq_port_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_data,
   input  logic              sel_ctl,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] pin_in,
   input  logic              line1,
   output logic [DATA_W-1:0] data_view,
   output logic [DATA_W-1:0] ctl_view,
   output logic [DATA_W-1:0] pin_out,
   output logic [DATA_W-1:0] pin_oe,
   output logic              line2_out,
   output logic              line2_oe,
   output logic              irq
);
   logic [DATA_W-1:0] dat_q, dir_q;
   logic [CTL_W-1:0]  ctl_q;
   logic              flag_q;
   logic              hit;

   logic wr_ctl, wr_dat, wr_dir, rd_clr;
   assign wr_ctl = sel_ctl  & wr_i;
   assign wr_dat = sel_data & wr_i &  ctl_q[CB_SEL];
   assign wr_dir = sel_data & wr_i & ~ctl_q[CB_SEL];
   assign rd_clr = sel_data & rd_i &  ctl_q[CB_SEL];

   eip_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_in  (line1),
      .rise_sel (ctl_q[CB_POL]),
      .hit      (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dat_q <= '0;
         dir_q <= '0;
         ctl_q <= '0;
      end else begin
         if (wr_dat) dat_q <= wdata_i;
         if (wr_dir) dir_q <= wdata_i;
         if (wr_ctl) ctl_q <= wdata_i[CTL_W-1:0];
      end
   end

   // edge has priority over a clearing read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (hit)    flag_q <= 1'b1;
      else if (rd_clr) flag_q <= 1'b0;
   end

   logic [DATA_W-1:0] port_mix;
   assign port_mix  = (dat_q & dir_q) | (pin_in & ~dir_q);
   assign data_view = ctl_q[CB_SEL] ? port_mix : dir_q;

   always_comb begin
      ctl_view                = '0;
      ctl_view[CTL_W-1:0]     = ctl_q;
      ctl_view[CB_RSV]        = 1'b0;
      ctl_view[CB_FLAG]       = flag_q;
   end

   assign pin_out   = dat_q;
   assign pin_oe    = dir_q;
   assign line2_oe  = ctl_q[CB_L2EN] & ctl_q[CB_L2FIX];
   assign line2_out = line2_oe & ctl_q[CB_L2LVL];
   assign irq       = flag_q & ctl_q[CB_IEN];

   // flag may only rise following a detected edge
   assert_flag_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(hit));

   // data read without a coincident edge clears the flag
   assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !hit) |=> !flag_q);

   // control writes never touch the flag
   assert_ctl_keeps_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && !hit) |=> (flag_q == $past(flag_q)));
endmodule

// File: rtl/edge_irq_port.sv
module edge_irq_port
   import edge_irq_port_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              rd,
   input  logic              wr,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] a_pin_in,
   output logic [DATA_W-1:0] a_pin_out,
   output logic [DATA_W-1:0] a_pin_oe,
   input  logic              a_line1,
   output logic              a_line2_out,
   output logic              a_line2_oe,
   output logic              a_irq,
   input  logic [DATA_W-1:0] b_pin_in,
   output logic [DATA_W-1:0] b_pin_out,
   output logic [DATA_W-1:0] b_pin_oe,
   input  logic              b_line1,
   output logic              b_line2_out,
   output logic              b_line2_oe,
   output logic              b_irq
);
   localparam int NSIDE = 2;

   if (DATA_W < 8) begin : g_bad_w
      $error("edge_irq_port: DATA_W must hold an 8-bit control register");
   end

   logic [NSIDE-1:0][DATA_W-1:0] pin_in_v, pin_out_v, pin_oe_v, dview_v, cview_v;
   logic [NSIDE-1:0]             line1_v, l2out_v, l2oe_v, irq_v;

   assign pin_in_v = {b_pin_in, a_pin_in};
   assign line1_v  = {b_line1, a_line1};

   for (genvar s = 0; s < NSIDE; s++) begin : g_side
      logic hit_side;
      assign hit_side = cs & (addr[1] == s[0]);
      eip_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) side_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .sel_data  (hit_side & ~addr[0]),
         .sel_ctl   (hit_side &  addr[0]),
         .rd_i      (rd),
         .wr_i      (wr),
         .wdata_i   (wdata),
         .pin_in    (pin_in_v[s]),
         .line1     (line1_v[s]),
         .data_view (dview_v[s]),
         .ctl_view  (cview_v[s]),
         .pin_out   (pin_out_v[s]),
         .pin_oe    (pin_oe_v[s]),
         .line2_out (l2out_v[s]),
         .line2_oe  (l2oe_v[s]),
         .irq       (irq_v[s])
      );
   end

   always_comb begin
      rdata = '0;
      if (cs && rd)
         rdata = addr[0] ? cview_v[addr[1]] : dview_v[addr[1]];
   end

   assign a_pin_out   = pin_out_v[0];
   assign a_pin_oe    = pin_oe_v[0];
   assign a_line2_out = l2out_v[0];
   assign a_line2_oe  = l2oe_v[0];
   assign a_irq       = irq_v[0];
   assign b_pin_out   = pin_out_v[1];
   assign b_pin_oe    = pin_oe_v[1];
   assign b_line2_out = l2out_v[1];
   assign b_line2_oe  = l2oe_v[1];
   assign b_irq       = irq_v[1];

   assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs && rd) |-> (rdata == '0));

   assert_rsv_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && rd && addr[0]) |-> !rdata[CB_RSV]);
endmodule

// File: tb/edge_irq_port_tb_top.sv
`timescale 1ns/1ps
module edge_irq_port_tb_top;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 0, rd = 0, wr = 0;
   logic [1:0] addr = '0;
   logic [W-1:0] wdata = '0, rdata;
   logic [W-1:0] a_pin_in = 8'h5A, a_pin_out, a_pin_oe;
   logic [W-1:0] b_pin_in = 8'hC3, b_pin_out, b_pin_oe;
   logic a_line1 = 0, b_line1 = 0;
   logic a_line2_out, a_line2_oe, a_irq, b_line2_out, b_line2_oe, b_irq;

   int n_run = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   edge_irq_port #(.DATA_W(W), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
      .wdata(wdata), .rdata(rdata),
      .a_pin_in(a_pin_in), .a_pin_out(a_pin_out), .a_pin_oe(a_pin_oe),
      .a_line1(a_line1), .a_line2_out(a_line2_out), .a_line2_oe(a_line2_oe),
      .a_irq(a_irq),
      .b_pin_in(b_pin_in), .b_pin_out(b_pin_out), .b_pin_oe(b_pin_oe),
      .b_line1(b_line1), .b_line2_out(b_line2_out), .b_line2_oe(b_line2_oe),
      .b_irq(b_irq));

   // vector fields: [18] read-check, [17:16] offset, [15:8] write data, [7:0] expected
   localparam int NV = 20;
   localparam logic [18:0] VEC [NV] = '{
      {1'b1, 2'd1, 8'h00, 8'h00},  // A ctl after reset
      {1'b1, 2'd0, 8'h00, 8'h00},  // A dir after reset
      {1'b0, 2'd0, 8'hF0, 8'h00},  // A dir = F0
      {1'b1, 2'd0, 8'h00, 8'hF0},
      {1'b0, 2'd1, 8'h04, 8'h00},  // select data
      {1'b1, 2'd1, 8'h00, 8'h04},
      {1'b0, 2'd0, 8'hA5, 8'h00},  // A latch = A5
      {1'b1, 2'd0, 8'h00, 8'hAA},  // mixed latch/pins
      {1'b0, 2'd1, 8'h00, 8'h00},  // back to direction
      {1'b1, 2'd0, 8'h00, 8'hF0},
      {1'b0, 2'd3, 8'hFF, 8'h00},  // B ctl, top bits ignored
      {1'b1, 2'd3, 8'h00, 8'h3F},
      {1'b0, 2'd2, 8'h3C, 8'h00},  // B latch
      {1'b1, 2'd2, 8'h00, 8'hC3},  // all inputs
      {1'b0, 2'd3, 8'h3B, 8'h00},  // B to direction
      {1'b1, 2'd2, 8'h00, 8'h00},
      {1'b0, 2'd2, 8'h0F, 8'h00},
      {1'b0, 2'd3, 8'h3F, 8'h00},
      {1'b1, 2'd2, 8'h00, 8'hCC},
      {1'b1, 2'd1, 8'h00, 8'h00}   // A untouched by B writes
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      cs = 1; wr = 1; addr = a; wdata = d;
      @(negedge clk);
      cs = 0; wr = 0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [W-1:0] v);
      @(negedge clk);
      cs = 1; rd = 1; addr = a;
      #1 v = rdata;
      @(negedge clk);
      cs = 0; rd = 0;
   endtask

   task automatic wait_clks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      logic [W-1:0] v;
      wait_clks(3);
      // R9 reset state
      check("R9 a_pin_oe", a_pin_oe, 0);
      check("R9 b_pin_oe", b_pin_oe, 0);
      check("R9 irq", {a_irq, b_irq}, 0);
      check("R9 line2 oe", {a_line2_oe, b_line2_oe}, 0);
      check("R1 idle rdata", rdata, 0);
      rst_n = 1;
      wait_clks(2);

      // table walk: R1 R2 R3 R7 R10
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][18]) begin
            bus_read(VEC[i][17:16], v);
            check($sformatf("R1/R2/R3 vector %0d", i), v, VEC[i][7:0]);
         end else begin
            bus_write(VEC[i][17:16], VEC[i][15:8]);
         end
      end
      check("R3 a_pin_oe", a_pin_oe, 8'hF0);
      check("R3 a_pin_out", a_pin_out, 8'hA5);
      check("R3 b_pin_oe", b_pin_oe, 8'h0F);
      check("R3 b_pin_out", b_pin_out, 8'h3C);
      check("R8 b line2", {b_line2_oe, b_line2_out}, 2'b11);
      check("R8 a line2 off", a_line2_oe, 0);

      // R4 wrong polarity: falling selected, rising applied
      bus_write(2'd1, 8'h05);
      a_line1 = 1;
      wait_clks(5);
      check("R4 no flag on rising", a_irq, 0);
      // R4 falling edge, latency three edges
      @(negedge clk) a_line1 = 0;
      @(posedge clk); @(posedge clk); #1;
      check("R4 not yet after two edges", a_irq, 0);
      @(posedge clk); #1;
      check("R4 flag after third edge", a_irq, 1);
      bus_read(2'd1, v);
      check("R4 ctl shows flag", v, 8'h85);
      // R5 flag kept while disabled
      bus_write(2'd1, 8'h04);
      check("R5 irq masked", a_irq, 0);
      bus_read(2'd1, v);
      check("R5 flag kept", v, 8'h84);
      bus_write(2'd1, 8'h05);
      check("R5 irq reasserts", a_irq, 1);
      // R6 data read clears
      bus_read(2'd0, v);
      check("R6 data read value", v, 8'hAA);
      check("R6 irq cleared", a_irq, 0);
      bus_read(2'd1, v);
      check("R6 ctl after clear", v, 8'h05);
      // R6 direction read keeps flag; rising polarity
      bus_write(2'd1, 8'h03);
      a_line1 = 1;
      wait_clks(5);
      check("R4 rising edge flag", a_irq, 1);
      bus_read(2'd0, v);
      check("R6 dir read value", v, 8'hF0);
      check("R6 dir read keeps flag", a_irq, 1);
      bus_write(2'd1, 8'h07);
      bus_read(2'd0, v);
      check("R6 data read clears", a_irq, 0);

      // R8 line 2 modes
      bus_write(2'd1, 8'h38);
      check("R8 high", {a_line2_oe, a_line2_out}, 2'b11);
      bus_write(2'd1, 8'h30);
      check("R8 low", {a_line2_oe, a_line2_out}, 2'b10);
      bus_write(2'd1, 8'h28);
      check("R8 bit4 clear releases", a_line2_oe, 0);
      bus_write(2'd1, 8'h18);
      check("R8 bit5 clear releases", a_line2_oe, 0);

      // R10 side B alone
      b_line1 = 1;
      wait_clks(5);
      check("R10 b_irq set", b_irq, 1);
      check("R10 a_irq unaffected", a_irq, 0);
      bus_write(2'd3, 8'hFF);
      bus_read(2'd3, v);
      check("R7 flag and rsv on write", v, 8'hBF);
      bus_read(2'd2, v);
      check("R10 b data read", v, 8'hCC);
      check("R6 b flag cleared", b_irq, 0);

      // R9 reset in mid-run
      @(negedge clk) rst_n = 0;
      wait_clks(2);
      check("R9 pins released", {a_pin_oe, b_pin_oe}, 0);
      check("R9 line2 released", {a_line2_oe, b_line2_oe}, 0);
      rst_n = 1;
      bus_read(2'd3, v);
      check("R9 ctl cleared", v, 8'h00);
      check("R9 irq low", {a_irq, b_irq}, 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule